// File: doc/BRIEF.md
# Windowed Spectral Peak Search

This block watches the output stream of an FFT, one complex bin per accepted cycle in natural index order, and finds the bin whose squared magnitude is largest within a programmable frequency window. The window has two parts that meet across the wrap of the spectrum. One part runs from bin 0 up to an upper bound. The other runs from a lower bound up to the last bin. This lets the caller limit the search to the frequency offsets that can actually occur.

At the end of each frame the block reports four things. The first is the index of the winning bin. The second is the same index mapped to a signed frequency bin. The third is the complex value of the winning bin, for a later phase estimate. The fourth is the energies of the two neighbouring bins, for a later parabolic interpolation step. Neighbours are taken circularly, so bin 0 and the last bin are adjacent. The search uses only an energy computation, counters and comparators.

Top module: `spec_peak_search`

## Requirements
- R1: After reset, `res_valid` is 0 and every result output is 0.
- R2: The energy of a bin is re*re + im*im. The reported index is the in-window bin with the largest energy. Bin indices count accepted bins, starting at 0 on the bin that carries `bin_first`.
- R3: A bin is a candidate only if its index is at most `win_hi` or at least `win_lo`. All other bins never win.
- R4: With `win_hi` = N/2-1 and `win_lo` = N/2, every bin is a candidate, so the result equals an unrestricted search.
- R5: When several candidates share the largest energy, the lowest index among them wins.
- R6: `res_freq` equals the index when the index is below N/2, and equals the index minus N otherwise (two's complement).
- R7: `res_re` and `res_im` carry the complex value of the winning bin exactly as received.
- R8: `res_en_left` and `res_en_right` are the energies of bins index-1 and index+1, taken modulo N. They are taken whether or not those bins lie in the window.
- R9: `res_valid` is high for exactly one cycle, in the cycle after bin N-1 is accepted. The result outputs hold their values until the next result.
- R10: Cycles with `bin_valid` low do not advance the bin count. A `bin_first` that arrives mid-frame discards the partial frame and starts a new one, and the partial frame produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bin_valid | input | 1 | A bin is presented this cycle |
| bin_first | input | 1 | The presented bin is bin 0 of a frame |
| bin_re | input | DW | Real part of the bin, signed |
| bin_im | input | DW | Imaginary part of the bin, signed |
| win_hi | input | log2(N) | Last index of the low part of the window |
| win_lo | input | log2(N) | First index of the high part of the window |
| res_valid | output | 1 | One-cycle result strobe |
| res_index | output | log2(N) | Index of the winning bin |
| res_freq | output | log2(N)+1 | Signed frequency bin of the winner |
| res_re | output | DW | Real part of the winning bin |
| res_im | output | DW | Imaginary part of the winning bin |
| res_en_left | output | 2*DW | Energy of the circular left neighbour |
| res_en_right | output | 2*DW | Energy of the circular right neighbour |

## Verification
Random frames are run over a full sweep of every pair of window bounds on a 16-bin configuration. This separates a correct window test from off-by-one comparisons and from a test that wrongly requires both bounds to hold. Frames with the peak placed at bin 0 and at the last bin show whether neighbour energies are taken circularly. Frames with two equal peaks expose a comparison that lets a later bin win a tie. Frames with idle gaps between bins, and a frame abandoned part way through by a new frame start, show whether the index counts only accepted bins and whether stale state leaks into the next result.

// File: rtl/spk_pkg.sv
package spk_pkg;
  localparam int DEF_NBINS = 16;
  localparam int DEF_DW    = 8;
endpackage

// File: rtl/spk_energy.sv
module spk_energy #(
  parameter int DW = spk_pkg::DEF_DW,
  localparam int EW = 2 * DW
) (
  input  logic signed [DW-1:0] re,
  input  logic signed [DW-1:0] im,
  output logic        [EW-1:0] en
);
  logic signed [EW-1:0] pr, pi;
  always_comb begin
    pr = EW'(re) * EW'(re);
    pi = EW'(im) * EW'(im);
    en = EW'($unsigned(pr)) + EW'($unsigned(pi));
  end
endmodule

// File: rtl/spk_window.sv
module spk_window #(
  parameter int NBINS = spk_pkg::DEF_NBINS,
  localparam int IW = $clog2(NBINS)
) (
  input  logic [IW-1:0] idx,
  input  logic [IW-1:0] win_hi,
  input  logic [IW-1:0] win_lo,
  output logic          in_win
);
  always_comb in_win = (idx <= win_hi) || (idx >= win_lo);
endmodule

// File: rtl/spk_tracker.sv
module spk_tracker #(
  parameter int NBINS = spk_pkg::DEF_NBINS,
  parameter int DW    = spk_pkg::DEF_DW,
  localparam int IW = $clog2(NBINS),
  localparam int EW = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid,
  input  logic                 first,
  input  logic signed [DW-1:0] re,
  input  logic signed [DW-1:0] im,
  input  logic        [EW-1:0] en,
  input  logic                 in_win,
  output logic        [IW-1:0] cur_idx,
  output logic                 res_valid,
  output logic        [IW-1:0] res_index,
  output logic signed [IW:0]   res_freq,
  output logic signed [DW-1:0] res_re,
  output logic signed [DW-1:0] res_im,
  output logic        [EW-1:0] res_en_left,
  output logic        [EW-1:0] res_en_right
);
  localparam logic [IW-1:0] LAST = IW'(NBINS - 1);
  localparam logic [IW-1:0] HALF = IW'(NBINS / 2);
  localparam logic [IW:0]   NB   = (IW+1)'(NBINS);

  logic [IW-1:0] cnt_q, cnt_n, bidx_q, bidx_n;
  logic signed [DW-1:0] bre_q, bre_n, bim_q, bim_n;
  logic [EW-1:0] ben_q, ben_n, left_q, left_n, right_q, right_n;
  logic [EW-1:0] prev_q, prev_n, e0_q, e0_n;
  logic pend_q, pend_n, load;
  logic signed [IW:0] freq_n;

  assign cur_idx = first ? '0 : cnt_q;

  always_comb begin
    cnt_n = cnt_q; bidx_n = bidx_q; bre_n = bre_q; bim_n = bim_q;
    ben_n = ben_q; left_n = left_q; right_n = right_q;
    prev_n = prev_q; e0_n = e0_q; pend_n = pend_q; load = 1'b0;
    if (valid) begin
      if (first) begin
        bidx_n = '0; bre_n = '0; bim_n = '0; ben_n = '0;
        left_n = '0; right_n = '0; pend_n = 1'b0;
      end
      if (pend_n) begin
        right_n = en;
        pend_n  = 1'b0;
      end
      if (cur_idx == '0) e0_n = en;
      if (in_win && (cur_idx == '0 || en > ben_n)) begin
        bidx_n = cur_idx; bre_n = re; bim_n = im; ben_n = en;
        left_n = (cur_idx == '0) ? '0 : prev_q;
        if (cur_idx == LAST) right_n = e0_n;
        else                 pend_n  = 1'b1;
      end
      prev_n = en;
      cnt_n  = (cur_idx == LAST) ? '0 : cur_idx + 1'b1;
      if (cur_idx == LAST) begin
        if (bidx_n == '0) left_n = en;
        load = 1'b1;
      end
    end
    freq_n = (bidx_n < HALF) ? $signed({1'b0, bidx_n}) : $signed({1'b0, bidx_n} - NB);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; bidx_q <= '0; bre_q <= '0; bim_q <= '0; ben_q <= '0;
      left_q <= '0; right_q <= '0; prev_q <= '0; e0_q <= '0; pend_q <= 1'b0;
    end else if (valid) begin
      cnt_q <= cnt_n; bidx_q <= bidx_n; bre_q <= bre_n; bim_q <= bim_n;
      ben_q <= ben_n; left_q <= left_n; right_q <= right_n;
      prev_q <= prev_n; e0_q <= e0_n; pend_q <= pend_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0; res_index <= '0; res_freq <= '0; res_re <= '0;
      res_im <= '0; res_en_left <= '0; res_en_right <= '0;
    end else begin
      res_valid <= load;
      if (load) begin
        res_index <= bidx_n; res_freq <= freq_n; res_re <= bre_n;
        res_im <= bim_n; res_en_left <= left_n; res_en_right <= right_n;
      end
    end
  end

  // R9
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R2
  peak_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !first) |=> ben_q >= $past(ben_q));
  // R3
  outside_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !first && !in_win) |=> bidx_q == $past(bidx_q));
  // R10
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && first) |=> (bidx_q == '0 && cnt_q == IW'(1)));
endmodule

// File: rtl/spec_peak_search.sv
module spec_peak_search #(
  parameter int NBINS = spk_pkg::DEF_NBINS,
  parameter int DW    = spk_pkg::DEF_DW,
  localparam int IW = $clog2(NBINS),
  localparam int EW = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bin_valid,
  input  logic                 bin_first,
  input  logic signed [DW-1:0] bin_re,
  input  logic signed [DW-1:0] bin_im,
  input  logic        [IW-1:0] win_hi,
  input  logic        [IW-1:0] win_lo,
  output logic                 res_valid,
  output logic        [IW-1:0] res_index,
  output logic signed [IW:0]   res_freq,
  output logic signed [DW-1:0] res_re,
  output logic signed [DW-1:0] res_im,
  output logic        [EW-1:0] res_en_left,
  output logic        [EW-1:0] res_en_right
);
  logic [EW-1:0] en;
  logic [IW-1:0] cur_idx;
  logic          in_win;

  spk_energy #(.DW(DW)) u_energy (.re(bin_re), .im(bin_im), .en(en));

  spk_window #(.NBINS(NBINS)) u_window (
    .idx(cur_idx), .win_hi(win_hi), .win_lo(win_lo), .in_win(in_win));

  spk_tracker #(.NBINS(NBINS), .DW(DW)) u_tracker (
    .clk(clk), .rst_n(rst_n), .valid(bin_valid), .first(bin_first),
    .re(bin_re), .im(bin_im), .en(en), .in_win(in_win), .cur_idx(cur_idx),
    .res_valid(res_valid), .res_index(res_index), .res_freq(res_freq),
    .res_re(res_re), .res_im(res_im), .res_en_left(res_en_left),
    .res_en_right(res_en_right));
endmodule

// File: tb/spec_peak_search_test.sv
module spec_peak_search_test;
  localparam int CLK_P = 10;
  localparam int N = 16;
  localparam int DW = 8;
  localparam int IW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bin_valid = 1'b0, bin_first = 1'b0;
  logic signed [DW-1:0] bin_re = '0, bin_im = '0;
  logic [IW-1:0] win_hi = '0, win_lo = '0;
  logic res_valid;
  logic [IW-1:0] res_index;
  logic signed [IW:0] res_freq;
  logic signed [DW-1:0] res_re, res_im;
  logic [2*DW-1:0] res_en_left, res_en_right;

  int total = 0, bad = 0;
  int xr[N], xi[N];

  always #(CLK_P/2) clk = ~clk;

  spec_peak_search #(.NBINS(N), .DW(DW)) uut (.*);

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int energy(int k);
    return xr[k]*xr[k] + xi[k]*xi[k];
  endfunction

  task automatic send(int k, bit f);
    @(negedge clk);
    bin_valid = 1'b1; bin_first = f;
    bin_re = DW'(xr[k]); bin_im = DW'(xi[k]);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bin_valid = 1'b0; bin_first = 1'b0;
    end
  endtask

  task automatic run_frame(int wu, int wl, int gap, string tag);
    int best, be, ef, seen;
    win_hi = IW'(wu); win_lo = IW'(wl);
    best = 0; be = -1; seen = 0;
    for (int k = 0; k < N; k++)
      if ((k <= wu || k >= wl) && energy(k) > be) begin best = k; be = energy(k); end
    for (int k = 0; k < N; k++) begin
      send(k, k == 0);
      if (k != N-1) begin
        idle(gap);
        if (gap > 0) seen += int'(res_valid);
      end
    end
    @(negedge clk);
    bin_valid = 1'b0; bin_first = 1'b0;
    chk({tag, " R10 no early result"}, seen, 0);
    chk("R9 strobe", res_valid, 1);
    chk({tag, " index"}, res_index, best);
    ef = (best < N/2) ? best : best - N;
    chk("R6 freq", res_freq, ef);
    chk("R7 re", res_re, xr[best]);
    chk("R7 im", res_im, xi[best]);
    chk("R8 left", res_en_left, energy((best + N - 1) % N));
    chk("R8 right", res_en_right, energy((best + 1) % N));
    @(negedge clk);
    chk("R9 pulse end", res_valid, 0);
    chk("R9 hold", res_index, best);
  endtask

  task automatic fill_rand();
    for (int k = 0; k < N; k++) begin
      xr[k] = $signed(DW'($urandom));
      xi[k] = $signed(DW'($urandom));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    chk("R1 valid", res_valid, 0);
    chk("R1 index", res_index, 0);
    chk("R1 freq", res_freq, 0);
    chk("R1 re", res_re, 0);
    chk("R1 left", res_en_left, 0);
    chk("R1 right", res_en_right, 0);
    rst_n = 1'b1;

    // R4 full range, R2 random data
    for (int t = 0; t < 20; t++) begin fill_rand(); run_frame(N/2-1, N/2, 0, "R4"); end

    // R3 sweep of every window
    for (int wu = 0; wu < N; wu++)
      for (int wl = 0; wl < N; wl++) begin fill_rand(); run_frame(wu, wl, 0, "R3"); end

    // R8 peak on bin 0 and on bin N-1
    fill_rand(); xr[0] = 127; xi[0] = 127; xr[N-1] = 90; run_frame(N/2-1, N/2, 0, "R8 wrap0");
    fill_rand(); xr[N-1] = -128; xi[N-1] = -128; xr[0] = 77; run_frame(N/2-1, N/2, 0, "R8 wrapN");
    // R8 neighbour outside window
    fill_rand(); xr[4] = 120; xi[4] = 0; xr[5] = 127; xi[5] = 127; run_frame(4, 15, 0, "R8 outside");

    // R5 ties
    for (int k = 0; k < N; k++) begin xr[k] = k % 3; xi[k] = 1; end
    xr[3] = 50; xi[3] = 0; xr[9] = 0; xi[9] = 50; xr[12] = -50; xi[12] = 0;
    run_frame(N/2-1, N/2, 0, "R5");
    for (int k = 0; k < N; k++) begin xr[k] = 5; xi[k] = -5; end
    run_frame(2, 10, 0, "R5 flat");

    // R10 gaps and restart
    for (int t = 0; t < 4; t++) begin fill_rand(); run_frame(N/2-1, N/2, t + 1, "R10 gap"); end
    fill_rand(); xr[2] = 127; xi[2] = 127;
    for (int k = 0; k < 7; k++) send(k, k == 0);
    @(negedge clk); bin_valid = 1'b0;
    chk("R10 partial no result", res_valid, 0);
    xr[2] = 1; xi[2] = 1;
    run_frame(N/2-1, N/2, 0, "R10 restart");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule